// File: doc/BRIEF.md
# 64-bit Rotate, Mask and Shift Unit

This combinational datapath block handles every rotate, mask, insert and shift operation of a 64-bit integer pipeline. A single left rotator, made of three cascaded 4:1 multiplexer stages, produces the rotated source. Two bound masks and a merge term then shape the rotated value into the result. Right shifts are done as left rotations by the negated amount. Word (32-bit) forms copy the low word of the source into both halves, so the 64-bit rotator also yields 32-bit rotations.

The caller selects the operation with a 3-bit code, a word flag and a signed flag. Plain rotate-and-mask forms pass zero on the insert operand. Rotate-and-insert forms pass the old destination value on it. Bit numbering is little-endian: bit 0 is the least significant bit. Mask bounds are bit indices in this numbering.

Top module: `rot_mask_shift`

## Requirements
- R1: With op code 0, word flag clear, upper bound 63, lower bound 0 and a zero insert operand, the result is the source rotated left by amount bits [5:0]. Amount bit 6 is ignored by all rotate codes (0, 1, 2).
- R2: With the word flag set, rotate codes rotate the low 32 bits of the source left by amount bits [4:0]. Only bits [4:0] of each bound are used, and mask bits 63..32 are always clear.
- R3: Op code 0 (clear both) masks bits lower..upper inclusive when lower <= upper. When lower > upper, it masks bits 0..upper together with bits lower..63.
- R4: Op code 1 (clear left) keeps bits upper..0 and ignores the lower bound. Op code 2 (clear right) keeps bits 63..lower and ignores the upper bound.
- R5: For rotate codes, the result is (rotated AND mask) OR (insert AND NOT mask).
- R6: Op code 3 is a logical left shift. The amount is bits [6:0] in 64-bit form and bits [5:0] in word form. An amount at or above the width gives zero. Word form clears result bits 63..32.
- R7: Op code 4 with the signed flag clear is a logical right shift, using the same amount fields as R6. An amount at or above the width gives zero, and word form clears bits 63..32.
- R8: Op code 4 with the signed flag set is an arithmetic right shift of the 64-bit source or of the low word. An amount at or above the width gives all sign bits. Word form sign-extends the 32-bit result to 64 bits.
- R9: The carry output is 1 only for an arithmetic right shift of a negative operand when at least one 1 bit is shifted out. It is 0 for every other operation.
- R10: Op codes 5, 6 and 7 give a zero result and a zero carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| ins_i | input | 64 | Insert operand, fills bits outside the mask for rotate codes |
| amt_i | input | 7 | Rotate or shift amount |
| hi_bnd_i | input | 6 | Upper mask bound (bit index) |
| lo_bnd_i | input | 6 | Lower mask bound (bit index) |
| op_i | input | 3 | 0 clear-both, 1 clear-left, 2 clear-right, 3 shift-left, 4 shift-right |
| w32_i | input | 1 | Word (32-bit) form |
| sgn_i | input | 1 | Arithmetic right shift |
| res_o | output | 64 | Result |
| cout_o | output | 1 | Carry out of arithmetic right shift |

## Verification
The unit holds no state, so a fault in a multiplexer stage, a mask generator or the merge select shows up at the result in the same cycle as the operands that reach it. A wrong stage select corrupts only the amounts whose bit pair picks it. A bounds fault shows only for particular upper and lower combinations, such as the wrapped case or out-of-range shifts. For these reasons every op code, both sizes and both signedness settings are driven with all 128 amount values, together with random operands and bounds.

// File: rtl/rot_mask_shift.sv
module rot_mask_shift (
  input  logic [63:0] src_i,
  input  logic [63:0] ins_i,
  input  logic [6:0]  amt_i,
  input  logic [5:0]  hi_bnd_i,
  input  logic [5:0]  lo_bnd_i,
  input  logic [2:0]  op_i,
  input  logic        w32_i,
  input  logic        sgn_i,
  output logic [63:0] res_o,
  output logic        cout_o
);
  localparam int          W = 64;
  localparam logic [2:0]  OP_RCB = 3'd0;
  localparam logic [2:0]  OP_RCL = 3'd1;
  localparam logic [2:0]  OP_RCR = 3'd2;
  localparam logic [2:0]  OP_SHL = 3'd3;
  localparam logic [2:0]  OP_SHR = 3'd4;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] x, s1, s2, s3, wmask, mhi, mlo, shr_m, mask, merge;
  logic [5:0]   rsh, hb, lb, ns;
  logic         ovr, sign;

  always_comb begin
    x     = w32_i ? {2{src_i[31:0]}} : src_i;
    wmask = w32_i ? {32'd0, 32'hFFFF_FFFF} : ONES;
    if (op_i == OP_SHR)
      rsh = w32_i ? {1'b0, 5'(-amt_i[4:0])} : 6'(-amt_i[5:0]);
    else
      rsh = w32_i ? {1'b0, amt_i[4:0]} : amt_i[5:0];

    case (rsh[1:0])
      2'd0: s1 = x;
      2'd1: s1 = {x[62:0], x[63]};
      2'd2: s1 = {x[61:0], x[63:62]};
      default: s1 = {x[60:0], x[63:61]};
    endcase
    case (rsh[3:2])
      2'd0: s2 = s1;
      2'd1: s2 = {s1[59:0], s1[63:60]};
      2'd2: s2 = {s1[55:0], s1[63:56]};
      default: s2 = {s1[51:0], s1[63:52]};
    endcase
    case (rsh[5:4])
      2'd0: s3 = s2;
      2'd1: s3 = {s2[47:0], s2[63:48]};
      2'd2: s3 = {s2[31:0], s2[63:32]};
      default: s3 = {s2[15:0], s2[63:16]};
    endcase

    hb    = w32_i ? {1'b0, hi_bnd_i[4:0]} : hi_bnd_i;
    lb    = w32_i ? {1'b0, lo_bnd_i[4:0]} : lo_bnd_i;
    mhi   = ONES >> (6'd63 - hb);
    mlo   = ONES << lb;
    ns    = w32_i ? {1'b0, amt_i[4:0]} : amt_i[5:0];
    ovr   = w32_i ? amt_i[5] : amt_i[6];
    shr_m = w32_i ? {32'd0, 32'hFFFF_FFFF >> ns[4:0]} : ONES >> ns;
    sign  = w32_i ? src_i[31] : src_i[63];

    case (op_i)
      OP_RCB:  mask = ((lb <= hb) ? (mhi & mlo) : (mhi | mlo)) & wmask;
      OP_RCL:  mask = mhi & wmask;
      OP_RCR:  mask = mlo & wmask;
      OP_SHL:  mask = ovr ? '0 : ((ONES << ns) & wmask);
      OP_SHR:  mask = ovr ? '0 : shr_m;
      default: mask = '0;
    endcase

    if (op_i == OP_RCB || op_i == OP_RCL || op_i == OP_RCR) merge = ins_i;
    else if (op_i == OP_SHR && sgn_i && sign)               merge = ONES;
    else                                                    merge = '0;

    res_o  = (s3 & mask) | (merge & ~mask);
    cout_o = (op_i == OP_SHR) && sgn_i && sign && (|(s3 & ~mask & wmask));

    if (!$isunknown({src_i, ins_i, amt_i, hi_bnd_i, lo_bnd_i, op_i, w32_i, sgn_i})) begin
      // R6: out-of-range left shift clears the result
      a_r6_shl_overrange: assert (!(op_i == OP_SHL && (w32_i ? amt_i[5] : amt_i[6])) || res_o == '0)
        else $error("R6 shift-left overrange not zero");
      // R7: word logical right shift leaves upper half clear
      a_r7_upper_clear: assert (!(op_i == OP_SHR && !sgn_i && w32_i) || res_o[63:32] == 32'd0)
        else $error("R7 upper word not clear");
      // R8: word arithmetic right shift is sign extended
      a_r8_sign_ext: assert (!(op_i == OP_SHR && sgn_i && w32_i) || res_o[63:32] == {32{res_o[31]}})
        else $error("R8 result not sign extended");
      // R9: carry only from arithmetic right shift of a negative value
      a_r9_cout_scope: assert (!cout_o || (op_i == OP_SHR && sgn_i && sign))
        else $error("R9 carry outside arithmetic shift");
      // R10: reserved codes produce nothing
      a_r10_reserved: assert (!(op_i > OP_SHR) || (res_o == '0 && !cout_o))
        else $error("R10 reserved code gave output");
    end
  end
endmodule

// File: tb/rot_mask_shift_test.sv
module rot_mask_shift_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] src, ins, res;
  logic [6:0]  amt;
  logic [5:0]  hb, lb;
  logic [2:0]  op;
  logic        w32, sgn, cout;

  rot_mask_shift uut (
    .src_i(src), .ins_i(ins), .amt_i(amt), .hi_bnd_i(hb), .lo_bnd_i(lb),
    .op_i(op), .w32_i(w32), .sgn_i(sgn), .res_o(res), .cout_o(cout)
  );

  typedef struct {
    logic [63:0] r;
    logic        c;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  function automatic logic [64:0] model(input logic [63:0] s, input logic [63:0] in,
                                        input logic [6:0] a, input logic [5:0] h6,
                                        input logic [5:0] l6, input logic [2:0] o,
                                        input logic w, input logic sg);
    logic [63:0] r, m, rot;
    logic [31:0] lw;
    logic c, neg, inm;
    int k, n, wid, h, l;
    r = '0; c = 1'b0; m = '0; rot = '0;
    wid = w ? 32 : 64;
    neg = w ? s[31] : s[63];
    h = w ? int'(h6[4:0]) : int'(h6);
    l = w ? int'(l6[4:0]) : int'(l6);
    case (o)
      3'd0, 3'd1, 3'd2: begin
        k = w ? int'(a[4:0]) : int'(a[5:0]);
        if (w) begin
          lw = s[31:0];
          lw = (lw << k) | (lw >> (32 - k));
          rot = {lw, lw};
        end else rot = (s << k) | (s >> (64 - k));
        for (int i = 0; i < 64; i++) begin
          if (o == 3'd0) inm = (l <= h) ? (i >= l && i <= h) : (i >= l || i <= h);
          else if (o == 3'd1) inm = (i <= h);
          else inm = (i >= l);
          if (w && i > 31) inm = 1'b0;
          m[i] = inm;
        end
        r = (rot & m) | (in & ~m);
      end
      3'd3: begin
        n = w ? int'(a[5:0]) : int'(a);
        if (n >= wid) r = '0;
        else if (w) r = {32'd0, s[31:0] << n};
        else r = s << n;
      end
      3'd4: begin
        n = w ? int'(a[5:0]) : int'(a);
        if (!sg) begin
          if (n >= wid) r = '0;
          else if (w) r = {32'd0, s[31:0] >> n};
          else r = s >> n;
        end else begin
          if (n >= wid) r = {64{neg}};
          else if (w) begin
            lw = $signed(s[31:0]) >>> n;
            r = {{32{lw[31]}}, lw};
          end else r = $signed(s) >>> n;
          if (neg)
            for (int i = 0; i < wid; i++)
              if (i < n && s[i]) c = 1'b1;
        end
      end
      default: r = '0;
    endcase
    return {c, r};
  endfunction

  task automatic drive(input logic [63:0] s, input logic [63:0] in, input logic [6:0] a,
                       input logic [5:0] h, input logic [5:0] l, input logic [2:0] o,
                       input logic w, input logic sg, input string tag);
    exp_t e;
    logic [64:0] mr;
    mr = model(s, in, a, h, l, o, w, sg);
    e.r = mr[63:0]; e.c = mr[64]; e.tag = tag;
    @(posedge clk); #1;
    src = s; ins = in; amt = a; hb = h; lb = l; op = o; w32 = w; sgn = sg;
    q.push_back(e);
  endtask

  task automatic check_lit(input logic [63:0] got, input logic [63:0] want, input string tag);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: res %h expected %h", tag, got, want);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (res !== e.r || cout !== e.c) begin
        n_bad++;
        $display("FAIL %s: res %h cout %b expected %h %b (op %0d w32 %b sgn %b amt %0d hb %0d lb %0d)",
                 e.tag, res, cout, e.r, e.c, op, w32, sgn, amt, hb, lb);
      end
    end
  end

  function automatic string tag_of(input logic [2:0] o, input logic sg);
    case (o)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return sg ? "R8/R9" : "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    src = '0; ins = '0; amt = '0; hb = '0; lb = '0; op = '0; w32 = 0; sgn = 0;
    @(negedge clk);
    check_lit(res, 64'd0, "R10 idle zero inputs");

    // R1 literal: rotate left by 4, full mask
    @(posedge clk); #1;
    src = 64'h0123_4567_89AB_CDEF; ins = '0; amt = 7'd4; hb = 6'd63; lb = 6'd0; op = 3'd0; w32 = 0; sgn = 0;
    @(negedge clk); check_lit(res, 64'h1234_5678_9ABC_DEF0, "R1 rotate by 4");
    // R1 amount bit 6 ignored
    @(posedge clk); #1; amt = 7'd68;
    @(negedge clk); check_lit(res, 64'h1234_5678_9ABC_DEF0, "R1 amount bit 6 ignored");
    // R2 literal word rotate
    @(posedge clk); #1; src = 64'hFFFF_0000_8000_0001; amt = 7'd1; hb = 6'd31; lb = 6'd0; w32 = 1;
    @(negedge clk); check_lit(res, 64'h0000_0000_0000_0003, "R2 word rotate");
    // R8 literal: word arithmetic shift of negative
    @(posedge clk); #1; src = 64'h0000_0000_8000_0000; amt = 7'd4; op = 3'd4; sgn = 1; w32 = 1;
    @(negedge clk); check_lit(res, 64'hFFFF_FFFF_F800_0000, "R8 word sign extend");
    check_lit({63'd0, cout}, 64'd0, "R9 no ones lost");
    @(posedge clk); #1; src = 64'h0000_0000_8000_0008;
    @(negedge clk); check_lit({63'd0, cout}, 64'd1, "R9 one bit lost");

    drive(64'h0123_4567_89AB_CDEF, '0, 7'd8, 6'd63, 6'd0, 3'd0, 0, 0, "R1");
    drive(64'h0123_4567_89AB_CDEF, '0, 7'd3, 6'd20, 6'd10, 3'd0, 1, 0, "R2");
    drive(64'hDEAD_BEEF_CAFE_F00D, '0, 7'd0, 6'd40, 6'd8, 3'd0, 0, 0, "R3 normal");
    drive(64'hDEAD_BEEF_CAFE_F00D, '0, 7'd0, 6'd8, 6'd40, 3'd0, 0, 0, "R3 wrapped");
    drive(64'hDEAD_BEEF_CAFE_F00D, '0, 7'd5, 6'd17, 6'd33, 3'd1, 0, 0, "R4 clear left");
    drive(64'hDEAD_BEEF_CAFE_F00D, '0, 7'd5, 6'd17, 6'd33, 3'd2, 0, 0, "R4 clear right");
    drive(64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_5555_AAAA, 7'd12, 6'd30, 6'd12, 3'd0, 0, 0, "R5 insert");
    drive(64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_5555_AAAA, 7'd12, 6'd30, 6'd12, 3'd0, 1, 0, "R5 word insert");
    drive(64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd64, 6'd0, 6'd0, 3'd3, 0, 0, "R6 overrange");
    drive(64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd32, 6'd0, 6'd0, 3'd3, 1, 0, "R6 word overrange");
    drive(64'hFFFF_FFFF_FFFF_FFFF, '0, 7'd63, 6'd0, 6'd0, 3'd4, 0, 0, "R7 edge");
    drive(64'h8000_0000_0000_0001, '0, 7'd100, 6'd0, 6'd0, 3'd4, 0, 1, "R8 overrange");
    drive(64'h0000_0000_7FFF_FFFF, '0, 7'd40, 6'd0, 6'd0, 3'd4, 1, 1, "R8 word positive overrange");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 7'd3, 6'd5, 6'd1, 3'd6, 0, 1, "R10 reserved");

    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 2; w++)
        for (int sg = 0; sg < 2; sg++)
          for (int a = 0; a < 128; a++)
            drive({$urandom, $urandom}, {$urandom, $urandom}, 7'(a),
                  6'($urandom), 6'($urandom), 3'(o), w[0], sg[0], tag_of(3'(o), sg[0]));

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule